// File: doc/BRIEF.md
# Interrupt Mitigation Delay Controller

This block drives one level-sensitive interrupt line from a cause vector and a mask vector. The line's natural level is "any unmasked cause pending". A new assertion of the line can be held back for a programmable mitigation window. A drop of the line always passes through at once. The aim is to batch interrupts: software sees one assertion for a burst of events, not one per event.

The window length is picked when a rising edge would occur and no window is already open. Up to three candidates take part: a throttle value that always applies, a transmit delay that applies only when a descriptor asked for a delayed interrupt and a transmit cause is pending, and a receive delay that applies only when the receive timer register is enabled and the receive cause is pending. The shortest nonzero candidate wins. The window is counted in 256 ns ticks, which a prescaler derives from the system clock. When the window expires, the line rises if an unmasked cause is still pending.

Four 16-bit delay registers are written through a small configuration port. A global enable turns mitigation off, and with it off every rising edge passes straight through.

Top module: `irq_moderator`

## Requirements
- R1: The pending set is `cause & mask`. `irq` is registered and, outside the mitigation cases below, equals "pending set nonzero" one clock after the inputs change.
- R2: When `irq` is high and the pending set becomes empty, `irq` goes low at the next clock edge, whether or not mitigation is enabled.
- R3: While a mitigation window is open, a new pending cause keeps `irq` low, and neither restarts nor changes the window.
- R4: The transmit candidate is 4 × transmit delay register. It counts only if the delay-request flag is set and cause bit 0 (descriptor written) or bit 1 (transmit queue empty) is pending.
- R5: The receive candidate is 4 × receive delay register. It counts only if the receive timer register is nonzero and cause bit 7 (receive timer) is pending.
- R6: The throttle register is always a candidate. The chosen delay d is the smallest nonzero candidate. One delay unit is 256 ns, i.e. 256/CLK_PERIOD_NS clocks. If d is nonzero, `irq` rises exactly d × 256/CLK_PERIOD_NS clocks after the edge at which the rising request was first seen, provided a cause is still pending.
- R7: If every qualified candidate is zero, `irq` rises at the first clock edge that sees the pending set nonzero.
- R8: The delay-request flag is set by any clock with `tx_desc_valid` and `tx_desc_ide` both high. It is cleared whenever a delay is computed. A request arriving in the same clock as a computation is kept for the next one.
- R9: At expiry the window closes and `irq` takes the current pending state. If nothing is pending, `irq` stays low, and a later cause opens a fresh window with a freshly computed delay.
- R10: `cfg_sel` picks the register: 0 throttle, 1 transmit delay, 2 receive delay, 3 receive timer. Only `cfg_wdata[15:0]` is stored. Writes during an open window do not change its remaining length.
- R11: With `mit_en` low, a rising request raises `irq` at the next clock edge with no delay.
- R12: A synchronous active-low reset closes any window, drives `irq` low, and clears the flag and all four delay registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mit_en | input | 1 | Enables mitigation windows |
| cause | input | CAUSE_W | Interrupt cause vector |
| mask | input | CAUSE_W | Interrupt enable mask |
| tx_desc_valid | input | 1 | A transmit descriptor is processed this clock |
| tx_desc_ide | input | 1 | That descriptor requests a delayed interrupt |
| cfg_wr | input | 1 | Write strobe for the delay registers |
| cfg_sel | input | 2 | Register select (0 throttle, 1 tx, 2 rx, 3 rx timer) |
| cfg_wdata | input | 32 | Write data, low 16 bits kept |
| irq | output | 1 | Interrupt line |

## Verification
Directed patterns raise each cause group on its own, so the window length shows which candidate was qualified: transmit with and without a pending delay request, a non-transmit cause with the request set, receive with the timer register zero and nonzero, and both groups together, so that the minimum rule is separated from a fixed priority. Further sequences drop and re-raise the cause inside a window, let a window expire with nothing pending, rewrite a register mid-window, disable mitigation and reset mid-window. These separate held edges, restarted windows and live register reads. A long random run with small register values then mixes writes, descriptor requests, enable toggles and cause/mask changes. It compares the line every clock against a reference computed in the bench.

// File: rtl/mit_pkg.sv
// Shared types for the interrupt mitigation controller.
// Assumes 16-bit delay registers and an 18-bit countdown (16 bits x 4).
package mit_pkg;
    localparam int REG_W = 16;
    localparam int DLY_W = REG_W + 2;

    typedef enum logic [1:0] {
        SEL_THROTTLE = 2'd0,
        SEL_TX_ABS   = 2'd1,
        SEL_RX_ABS   = 2'd2,
        SEL_RX_TMR   = 2'd3
    } mit_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] thr;
        logic [REG_W-1:0] tx_abs;
        logic [REG_W-1:0] rx_abs;
        logic [REG_W-1:0] rx_tmr;
    } mit_regs_t;
endpackage

// File: rtl/mit_delay_regs.sv
// Holds the four mitigation delay registers.
// Assumes: one write per clock; only the low REG_W bits of the data are kept.
module mit_delay_regs
    import mit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output mit_regs_t         regs
);
    logic [REG_W-1:0] wlow;
    logic             unused_hi;

    assign wlow      = wdata[REG_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:REG_W];

    // Register update: reset clears all, a write loads the selected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr) begin
            case (mit_sel_e'(sel))
                SEL_THROTTLE: regs.thr    <= wlow;
                SEL_TX_ABS:   regs.tx_abs <= wlow;
                SEL_RX_ABS:   regs.rx_abs <= wlow;
                default:      regs.rx_tmr <= wlow;
            endcase
        end
    end

    // R10: without a write the registers keep their values
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(regs));
endmodule

// File: rtl/mit_delay_select.sv
// Combinational choice of the mitigation delay from pending causes.
// Assumes the cause bit positions of the transmit and receive groups are
// given as parameters; the result is 0 when no candidate is nonzero.
module mit_delay_select
    import mit_pkg::*;
#(
    parameter int CAUSE_W  = 32,
    parameter int TXDW_BIT = 0,
    parameter int TXQE_BIT = 1,
    parameter int RXT_BIT  = 7
) (
    input  mit_regs_t          regs,
    input  logic [CAUSE_W-1:0] pending,
    input  logic               ide_flag,
    output logic [DLY_W-1:0]   dly
);
    // Keeps the smaller nonzero of the running value and a candidate.
    function automatic logic [DLY_W-1:0] shortest(input logic [DLY_W-1:0] cur,
                                                  input logic [DLY_W-1:0] cand);
        if (cand != '0 && (cur == '0 || cand < cur)) return cand;
        return cur;
    endfunction

    logic             tx_ok;
    logic             rx_ok;
    logic [DLY_W-1:0] tx_cand;
    logic [DLY_W-1:0] rx_cand;
    logic [DLY_W-1:0] thr_cand;

    assign tx_ok    = ide_flag && (pending[TXDW_BIT] || pending[TXQE_BIT]);
    assign rx_ok    = (regs.rx_tmr != '0) && pending[RXT_BIT];
    assign tx_cand  = tx_ok ? {regs.tx_abs, 2'b00} : '0;
    assign rx_cand  = rx_ok ? {regs.rx_abs, 2'b00} : '0;
    assign thr_cand = {2'b00, regs.thr};

    // Fold the three candidates into the shortest nonzero delay.
    always_comb begin
        dly = '0;
        dly = shortest(dly, tx_cand);
        dly = shortest(dly, rx_cand);
        dly = shortest(dly, thr_cand);
    end
endmodule

// File: rtl/mit_prescaler.sv
// Emits a one-clock tick every TICK_CYC clocks while the window runs.
// Assumes TICK_CYC >= 2; clr restarts the phase so a window is exact.
module mit_prescaler #(
    parameter int TICK_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

    logic [PW-1:0] phase;

    // Phase counter: restarts on clear, wraps after LAST while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    assign tick = run && (phase == LAST);

    // R6: ticks are never back to back when the period is longer than one
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/mit_countdown.sv
// Mitigation window timer: loads a tick count, counts it down, and flags
// expiry on the tick that takes it to zero. Assumes load only when idle.
module mit_countdown
    import mit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             run,
    output logic             expire
);
    logic [DLY_W-1:0] cnt;

    // Countdown state: load opens the window, the last tick closes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt - 1'b1;
            if (cnt == DLY_W'(1)) run <= 1'b0;
        end
    end

    assign expire = tick && (cnt == DLY_W'(1));

    // R9: an open window never holds a zero count
    a_r9_live_count: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
    // R10: between ticks the remaining length does not move
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/irq_moderator.sv
// Interrupt mitigation controller top. Holds back rising edges of the
// interrupt line for a window picked from the delay registers; falling
// edges pass at once. Assumes CLK_PERIOD_NS divides 256 and is <= 128.
module irq_moderator
    import mit_pkg::*;
#(
    parameter int CAUSE_W       = 32,
    parameter int CLK_PERIOD_NS = 8,
    parameter int TXDW_BIT      = 0,
    parameter int TXQE_BIT      = 1,
    parameter int RXT_BIT       = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mit_en,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [CAUSE_W-1:0] mask,
    input  logic               tx_desc_valid,
    input  logic               tx_desc_ide,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic               irq
);
    localparam int TICK_CYC = 256 / CLK_PERIOD_NS;

    mit_regs_t          regs;
    logic [CAUSE_W-1:0] pending;
    logic [DLY_W-1:0]   dly;
    logic               ide_q;
    logic               tick;
    logic               tmr_run;
    logic               tmr_expire;
    logic               rise_req;
    logic               compute;
    logic               start;

    assign pending  = cause & mask;
    assign rise_req = !irq && (pending != '0);
    assign compute  = rise_req && !tmr_run && mit_en;
    assign start    = compute && (dly != '0);

    mit_delay_regs #(.DATA_W(32)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
        .wdata(cfg_wdata), .regs(regs)
    );

    mit_delay_select #(
        .CAUSE_W(CAUSE_W), .TXDW_BIT(TXDW_BIT),
        .TXQE_BIT(TXQE_BIT), .RXT_BIT(RXT_BIT)
    ) sel_i (
        .regs(regs), .pending(pending), .ide_flag(ide_q), .dly(dly)
    );

    mit_prescaler #(.TICK_CYC(TICK_CYC)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr(start), .run(tmr_run), .tick(tick)
    );

    mit_countdown cnt_i (
        .clk(clk), .rst_n(rst_n), .load(start), .load_val(dly),
        .tick(tick), .run(tmr_run), .expire(tmr_expire)
    );

    // Delay-request flag: accumulates descriptor requests, cleared on use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ide_q <= 1'b0;
        end else begin
            ide_q <= (ide_q && !compute) || (tx_desc_valid && tx_desc_ide);
        end
    end

    // Line level: expiry re-evaluates, held edges wait, others follow pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (tmr_expire) begin
            irq <= (pending != '0);
        end else if (rise_req) begin
            if (tmr_run)       irq <= 1'b0;
            else if (!mit_en)  irq <= 1'b1;
            else               irq <= (dly == '0);
        end else begin
            irq <= (pending != '0);
        end
    end

    // R2: an empty pending set drops the line on the next edge
    a_r2_fast_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pending == '0) |=> !irq);
    // R3: an open window keeps the line low until it expires
    a_r3_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && !tmr_expire) |=> !irq);
    // R11: with mitigation off a rising request passes at once
    a_r11_no_delay_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mit_en && rise_req && !tmr_run) |=> irq);
    // R7: a zero delay raises the line without opening a window
    a_r7_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (compute && dly == '0) |=> (irq && !tmr_run));
    // R8: a computation clears the flag unless a new request arrives
    a_r8_flag_used: assert property (@(posedge clk) disable iff (!rst_n)
        (compute && !(tx_desc_valid && tx_desc_ide)) |=> !ide_q);
    // R6: the chosen delay never exceeds a nonzero throttle value
    a_r6_throttle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (regs.thr != '0) |-> (dly != '0 && dly <= {2'b00, regs.thr}));
endmodule

// File: tb/irq_moderator_tb_top.sv
module irq_moderator_tb_top;
    localparam int CLK_NS = 8;
    localparam int TICK   = 256 / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mit_en = 1'b0;
    logic [31:0] cause = '0;
    logic [31:0] mask = '0;
    logic        tx_desc_valid = 1'b0;
    logic        tx_desc_ide = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        irq;

    int checks = 0;
    int bad = 0;

    irq_moderator #(.CLK_PERIOD_NS(CLK_NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .mit_en(mit_en), .cause(cause), .mask(mask),
        .tx_desc_valid(tx_desc_valid), .tx_desc_ide(tx_desc_ide),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Reference model state, advanced at each rising edge.
    logic        m_irq = 1'b0;
    logic        m_run = 1'b0;
    int          m_left = 0;
    logic        m_ide = 1'b0;
    logic [15:0] m_thr = '0, m_tx = '0, m_rx = '0, m_rt = '0;

    function automatic int pick(input int cur, input int cand);
        if (cand != 0 && (cur == 0 || cand < cur)) return cand;
        return cur;
    endfunction

    function automatic int model_delay(input logic [31:0] p);
        int d = 0;
        if (m_ide && (p[0] || p[1])) d = pick(d, 4 * int'(m_tx));
        if (m_rt != 0 && p[7])       d = pick(d, 4 * int'(m_rx));
        d = pick(d, int'(m_thr));
        return d;
    endfunction

    always @(posedge clk) begin
        logic [31:0] p;
        logic        used;
        int          d;
        if (!rst_n) begin
            m_irq = 0; m_run = 0; m_left = 0; m_ide = 0;
            m_thr = 0; m_tx = 0; m_rx = 0; m_rt = 0;
        end else begin
            p = cause & mask;
            used = 0;
            if (m_run && m_left == 1) begin
                m_run = 0;
                m_irq = (p != 0);
            end else begin
                if (m_run) m_left--;
                if (!m_irq && p != 0) begin
                    if (!m_run) begin
                        if (mit_en) begin
                            d = model_delay(p);
                            used = 1;
                            if (d != 0) begin m_run = 1; m_left = d * TICK; end
                            else m_irq = 1;
                        end else m_irq = 1;
                    end
                end else m_irq = (p != 0);
            end
            m_ide = (m_ide && !used) || (tx_desc_valid && tx_desc_ide);
            if (cfg_wr) begin
                case (cfg_sel)
                    2'd0: m_thr = cfg_wdata[15:0];
                    2'd1: m_tx  = cfg_wdata[15:0];
                    2'd2: m_rx  = cfg_wdata[15:0];
                    default: m_rt = cfg_wdata[15:0];
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: sample at the falling edge against the model, then return.
    task automatic step();
        @(negedge clk);
        check(irq === m_irq, "R1 line vs reference", int'(irq), int'(m_irq));
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] v);
        cfg_wr = 1; cfg_sel = s; cfg_wdata = v;
        step();
        cfg_wr = 0;
    endtask

    task automatic desc_req();
        tx_desc_valid = 1; tx_desc_ide = 1;
        step();
        tx_desc_valid = 0; tx_desc_ide = 0;
    endtask

    // Raise a cause, count falling edges until the line is high, then clear.
    task automatic measure(input logic [31:0] c, input string req, input int exp);
        int n = 0;
        cause = c;
        do begin step(); n++; end while (!irq && n < 5000);
        check(n == exp, req, n, exp);
        cause = 0;
        step();
        check(irq == 0, "R2 fall after clear", int'(irq), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int n;
        int unsigned seed;
        seed = $urandom(32'd4242);
        mask = '1;
        step(); step();
        check(irq == 0, "R12 reset level", int'(irq), 0);
        rst_n = 1;
        step();

        // R11: mitigation off ignores a nonzero throttle
        wr_reg(2'd0, 32'd5);
        measure(32'h1, "R11 no delay when disabled", 1);
        mit_en = 1;
        wr_reg(2'd0, 32'd0);
        measure(32'h1, "R7 zero delay immediate", 1);
        wr_reg(2'd0, 32'd3);
        measure(32'h1, "R6 throttle window", 3 * TICK + 1);

        // R4 transmit candidate qualified by the flag and cause bits 0/1
        wr_reg(2'd1, 32'd2);
        wr_reg(2'd0, 32'd20);
        desc_req();
        measure(32'h1, "R4 tx candidate chosen", 8 * TICK + 1);
        measure(32'h2, "R8 flag cleared after use", 20 * TICK + 1);
        desc_req();
        measure(32'h10, "R4 non-tx cause ignores tx", 20 * TICK + 1);

        // R5 receive candidate qualified by timer register and bit 7
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'd1);
        measure(32'h80, "R5 rx timer zero", 20 * TICK + 1);
        wr_reg(2'd3, 32'd9);
        measure(32'h80, "R5 rx candidate chosen", 4 * TICK + 1);

        // R6 shortest nonzero among tx and rx
        wr_reg(2'd0, 32'd0);
        wr_reg(2'd1, 32'd3);
        wr_reg(2'd2, 32'd2);
        desc_req();
        measure(32'h81, "R6 shortest candidate", 8 * TICK + 1);

        // R10 upper half of write data discarded
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'd0);
        wr_reg(2'd3, 32'd0);
        wr_reg(2'd0, 32'h0001_0002);
        measure(32'h1, "R10 low half kept", 2 * TICK + 1);

        // R10 rewrite during an open window does not stretch it
        cause = 32'h1; n = 0;
        do begin
            step(); n++;
            if (n == 10) begin cfg_wr = 1; cfg_sel = 2'd0; cfg_wdata = 32'd100; end
            if (n == 11) cfg_wr = 0;
        end while (!irq && n < 5000);
        check(n == 2 * TICK + 1, "R10 window fixed at start", n, 2 * TICK + 1);
        cause = 0; step();
        wr_reg(2'd0, 32'd4);

        // R3 drop and re-raise inside the window; R9 rises at expiry
        cause = 32'h1; n = 0;
        do begin
            step(); n++;
            if (n == 20) cause = 0;
            if (n == 40) cause = 32'h1;
        end while (!irq && n < 5000);
        check(n == 4 * TICK + 1, "R3 held until expiry", n, 4 * TICK + 1);
        cause = 0; step();

        // R9 expiry with nothing pending keeps the line low
        wr_reg(2'd0, 32'd2);
        cause = 32'h1;
        repeat (10) step();
        cause = 0;
        repeat (3 * TICK) step();
        check(irq == 0, "R9 expiry with empty set", int'(irq), 0);
        measure(32'h1, "R9 fresh window after expiry", 2 * TICK + 1);

        // R12 reset inside a window
        wr_reg(2'd0, 32'd4);
        cause = 32'h1;
        repeat (10) step();
        rst_n = 0;
        step(); step();
        check(irq == 0, "R12 reset mid window", int'(irq), 0);
        rst_n = 1;
        step();
        check(irq == 1, "R12 registers cleared", int'(irq), 1);
        cause = 0; step();

        // Random mix checked every clock against the reference (R1)
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 8 == 0) begin
                cause = '0;
                cause[0] = $urandom % 2; cause[1] = $urandom % 2;
                cause[4] = $urandom % 2; cause[7] = $urandom % 2;
            end
            if ($urandom % 32 == 0) mask = ($urandom % 2) ? '1 : 32'h0000_0081;
            cfg_wr = ($urandom % 16 == 0);
            cfg_sel = 2'($urandom % 4);
            cfg_wdata = {16'($urandom), 16'($urandom % 4)};
            tx_desc_valid = ($urandom % 8 == 0);
            tx_desc_ide = $urandom % 2;
            if ($urandom % 64 == 0) mit_en = ~mit_en;
            step();
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule